// File: doc/BRIEF.md
# Cascaded FIFO Slice Token Controller

This block sits next to one FIFO slice and decides whether that slice may accept the shared write strobe, the shared read strobe, both or neither. Several slices joined in a ring then behave as one deeper FIFO. Write ownership and read ownership each travel around the ring as a token. The slice that fills its last physical location hands the write token to its neighbour with a one-cycle active-low pulse. The slice that empties its last location does the same with the read token. The receiving slice starts its local pointer at location zero, so words cross slice boundaries in arrival order.

Write tokens and read tokens travel on separate lines. This lets the two hand-offs happen in the same cycle in different slices without any ambiguity. The mode is captured while reset is held. A slice whose incoming write-token line is held low while its first-slice input is high runs standalone. In standalone mode it owns both tokens permanently, and its outgoing write-token line carries an active-low half-full indication instead of a token. Any other combination selects ring mode. The storage array, the pointers and the composite full/empty flags (formed outside by combining the per-slice flags) are not part of this block.

Top module: `xtok_slice_ctl`

## Requirements
- R1: While `rst_n` is low, `standalone` is captured as (`wtok_in_n`==0 and `first_n`==1). From the first cycle after reset it stays constant, whatever those inputs do.
- R2: In the first cycle after reset in ring mode, a slice with `first_n`==0 holds both `wr_token` and `rd_token` at 1. A slice with `first_n`==1 holds both at 0.
- R3: `wr_en` is 1 only when `wr_stb` and `wr_token` are both 1, and `rd_en` is 1 only when `rd_stb` and `rd_token` are both 1. A strobe arriving at a slice without the token has no effect on its outputs or tokens.
- R4: In ring mode, `wtok_out_n` is 0 in exactly the cycle where the slice holds the write token with `wr_stb`=1 and `wr_last`=1. After that clock edge `wr_token` is 0, unless a token arrives in the same cycle.
- R5: In ring mode, `wtok_in_n`=0 at a clock edge sets `wr_token` to 1 after that edge. Without a pulse on either side, the token holds its value.
- R6: `rtok_out_n` and `rd_token` follow the rules of R4 and R5, using `rd_stb`, `rd_last` and `rtok_in_n`. In a ring, exactly one slice holds each token at all times after reset.
- R7: In standalone mode, `wr_token`=`rd_token`=1, `wtok_out_n` equals the inverse of `half_full`, and `rtok_out_n` is 1.
- R8: A write hand-off and a read hand-off in the same cycle, in different slices, are each carried out on their own lines. Both tokens advance at the same edge.
- R9: While `rst_n` is low, `wtok_out_n` and `rtok_out_n` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset; mode captured while low |
| first_n | input | 1 | Low marks the slice that owns both tokens after reset |
| wtok_in_n | input | 1 | Write-token pulse from previous slice (active low); mode select during reset |
| rtok_in_n | input | 1 | Read-token pulse from previous slice (active low) |
| wr_stb | input | 1 | Shared write strobe |
| rd_stb | input | 1 | Shared read strobe |
| wr_last | input | 1 | Local write pointer is at the last location |
| rd_last | input | 1 | Local read pointer is at the last location |
| half_full | input | 1 | Local half-full flag, forwarded in standalone mode |
| wr_en | output | 1 | Local write enable |
| rd_en | output | 1 | Local read enable |
| wtok_out_n | output | 1 | Write-token pulse to next slice, or inverted half-full when standalone |
| rtok_out_n | output | 1 | Read-token pulse to next slice (active low) |
| wr_token | output | 1 | Slice currently owns writing |
| rd_token | output | 1 | Slice currently owns reading |
| standalone | output | 1 | Captured mode: 1 = standalone, 0 = ring |

## Verification
A write hand-off and a read hand-off can land in the same cycle, one in the slice being filled and one in the slice being drained. The bench sets this up by writing one slice's worth of words and then issuing combined write+read cycles. On the fourth such cycle, one slice writes its last location while another reads its last location. The bench checks that both pulses appear together on their own lines, and that each token lands on the correct next slice at the same edge. A longer mixed stream then repeats such collisions, and the scoreboard confirms that the output order is unbroken.

// File: rtl/xtok_pkg.sv
package xtok_pkg;

  typedef enum logic {
    MODE_RING = 1'b0,
    MODE_SOLO = 1'b1
  } xtok_mode_e;

  localparam int unsigned NUM_KINDS = 2;
  localparam int unsigned KIND_WR   = 0;
  localparam int unsigned KIND_RD   = 1;

  // Mode decode applied while reset is held.
  function automatic xtok_mode_e mode_decode(input logic tok_in_n, input logic first_n);
    return (!tok_in_n && first_n) ? MODE_SOLO : MODE_RING;
  endfunction

  // A slice gives away its token when it consumes its last location.
  function automatic logic pass_fire(input logic own, input logic stb, input logic last);
    return own & stb & last;
  endfunction

  // Ownership after the edge: keep unless given away, gain on arrival.
  function automatic logic token_next(input logic own, input logic give, input logic recv);
    return (own & ~give) | recv;
  endfunction

endpackage

// File: rtl/xtok_mode_latch.sv
module xtok_mode_latch
  import xtok_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in_n,
  input  logic       first_n,
  output xtok_mode_e mode,
  output logic       is_first
);

  xtok_mode_e mode_q;
  logic       first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_decode(tok_in_n, first_n);
      first_q <= ~first_n;
    end
  end

  assign mode     = mode_q;
  assign is_first = first_q;

endmodule

// File: rtl/xtok_token_cell.sv
module xtok_token_cell
  import xtok_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic solo,
  input  logic init_own,
  input  logic stb,
  input  logic last,
  input  logic recv_n,
  output logic own,
  output logic give,
  output logic en
);

  logic own_q;
  logic recv;

  assign recv = ~recv_n & ~solo;
  assign give = rst_n & ~solo & pass_fire(own_q, stb, last);
  assign en   = rst_n & own_q & stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= init_own;
    end else if (solo) begin
      own_q <= 1'b1;
    end else begin
      own_q <= token_next(own_q, give, recv);
    end
  end

  assign own = own_q;

endmodule

// File: rtl/xtok_slice_ctl.sv
module xtok_slice_ctl
  import xtok_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_n,
  input  logic wtok_in_n,
  input  logic rtok_in_n,
  input  logic wr_stb,
  input  logic rd_stb,
  input  logic wr_last,
  input  logic rd_last,
  input  logic half_full,
  output logic wr_en,
  output logic rd_en,
  output logic wtok_out_n,
  output logic rtok_out_n,
  output logic wr_token,
  output logic rd_token,
  output logic standalone
);

  xtok_mode_e mode;
  logic       is_first;
  logic       solo;
  logic       init_own;

  logic [NUM_KINDS-1:0] k_stb;
  logic [NUM_KINDS-1:0] k_last;
  logic [NUM_KINDS-1:0] k_recv_n;
  logic [NUM_KINDS-1:0] k_own;
  logic [NUM_KINDS-1:0] k_give;
  logic [NUM_KINDS-1:0] k_en;

  xtok_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_in_n (wtok_in_n),
    .first_n  (first_n),
    .mode     (mode),
    .is_first (is_first)
  );

  assign solo = (mode == MODE_SOLO);

  // Value loaded on each reset cycle, decoded from the live pins so the
  // first cycle after reset already reflects the captured configuration.
  assign init_own = (mode_decode(wtok_in_n, first_n) == MODE_SOLO) | ~first_n;

  assign k_stb[KIND_WR]    = wr_stb;
  assign k_stb[KIND_RD]    = rd_stb;
  assign k_last[KIND_WR]   = wr_last;
  assign k_last[KIND_RD]   = rd_last;
  assign k_recv_n[KIND_WR] = wtok_in_n;
  assign k_recv_n[KIND_RD] = rtok_in_n;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    xtok_token_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .solo     (solo),
      .init_own (init_own),
      .stb      (k_stb[k]),
      .last     (k_last[k]),
      .recv_n   (k_recv_n[k]),
      .own      (k_own[k]),
      .give     (k_give[k]),
      .en       (k_en[k])
    );
  end

  assign wr_en      = k_en[KIND_WR];
  assign rd_en      = k_en[KIND_RD];
  assign wr_token   = k_own[KIND_WR];
  assign rd_token   = k_own[KIND_RD];
  assign standalone = solo;

  always_comb begin
    if (!rst_n) begin
      wtok_out_n = 1'b1;
      rtok_out_n = 1'b1;
    end else if (solo) begin
      wtok_out_n = ~half_full;
      rtok_out_n = 1'b1;
    end else begin
      wtok_out_n = ~k_give[KIND_WR];
      rtok_out_n = ~k_give[KIND_RD];
    end
  end

  logic unused_first;
  assign unused_first = is_first;

endmodule

// File: rtl/xtok_slice_ctl_chk.sv
module xtok_slice_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic first_n,
  input logic wtok_in_n,
  input logic rtok_in_n,
  input logic wr_stb,
  input logic rd_stb,
  input logic wr_last,
  input logic rd_last,
  input logic half_full,
  input logic wr_en,
  input logic rd_en,
  input logic wtok_out_n,
  input logic rtok_out_n,
  input logic wr_token,
  input logic rd_token,
  input logic standalone
);

  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(standalone));

  a_r3_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_stb && wr_token));

  a_r3_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_stb && rd_token));

  a_r4_pass_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (!standalone && !wtok_out_n) |-> (wr_token && wr_stb && wr_last));

  a_r4_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!standalone && !wtok_out_n && wtok_in_n) |=> !wr_token);

  a_r5_wr_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!standalone && !wtok_in_n) |=> wr_token);

  a_r6_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtok_out_n && rtok_in_n) |=> !rd_token);

  a_r6_rd_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!standalone && !rtok_in_n) |=> rd_token);

  a_r7_solo_lines: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> (rtok_out_n && (wtok_out_n == !half_full)));

  a_r7_solo_owns: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> (wr_token && rd_token));

endmodule

bind xtok_slice_ctl xtok_slice_ctl_chk chk_i (.*);

// File: tb/xtok_slice_ctl_tb_top.sv
module xtok_slice_ctl_tb_top;

  localparam int NS = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic wr_stb, rd_stb;
  logic [7:0] din;

  logic [NS-1:0] wr_en, rd_en, wtok_o, rtok_o, wtok_t, rtok_t, solo_m, wl, rl;
  logic [7:0] smem [NS][DEPTH];
  logic [1:0] wp [NS];
  logic [1:0] rp [NS];

  for (genvar s = 0; s < NS; s++) begin : g_slice
    assign wl[s] = (wp[s] == 2'(DEPTH - 1));
    assign rl[s] = (rp[s] == 2'(DEPTH - 1));
    xtok_slice_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .first_n((s == 0) ? 1'b0 : 1'b1),
      .wtok_in_n(wtok_o[(s + NS - 1) % NS]),
      .rtok_in_n(rtok_o[(s + NS - 1) % NS]),
      .wr_stb(wr_stb), .rd_stb(rd_stb),
      .wr_last(wl[s]), .rd_last(rl[s]), .half_full(1'b0),
      .wr_en(wr_en[s]), .rd_en(rd_en[s]),
      .wtok_out_n(wtok_o[s]), .rtok_out_n(rtok_o[s]),
      .wr_token(wtok_t[s]), .rd_token(rtok_t[s]),
      .standalone(solo_m[s])
    );
    // Slice storage and pointers modelled in the bench environment.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[s] <= '0;
        rp[s] <= '0;
      end else begin
        if (wr_en[s]) begin
          smem[s][wp[s]] <= din;
          wp[s] <= wp[s] + 2'd1;
        end
        if (rd_en[s]) rp[s] <= rp[s] + 2'd1;
      end
    end
  end

  // Standalone instance
  logic s_xin, s_wr, s_rd, s_wl, s_rl, s_hf;
  logic s_wen, s_ren, s_wo, s_ro, s_wt, s_rt, s_mode;
  xtok_slice_ctl solo_i (
    .clk(clk), .rst_n(rst_n), .first_n(1'b1),
    .wtok_in_n(s_xin), .rtok_in_n(1'b1),
    .wr_stb(s_wr), .rd_stb(s_rd), .wr_last(s_wl), .rd_last(s_rl), .half_full(s_hf),
    .wr_en(s_wen), .rd_en(s_ren), .wtok_out_n(s_wo), .rtok_out_n(s_ro),
    .wr_token(s_wt), .rd_token(s_rt), .standalone(s_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cnt = 0;
  bit run_mon = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; return 1 ns later for checks.
  task automatic cyc(input logic w, input logic r);
    @(negedge clk);
    wr_stb = w;
    rd_stb = r;
    if (w) begin
      din = din + 8'd7;
      exp_q.push_back(din);
      cnt++;
    end
    if (r) cnt--;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; run_mon = 1'b0;
    s_xin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 ring token outputs idle in reset", {29'd0, wtok_o}, 32'h7);
    check("R9 ring read-token outputs idle in reset", {29'd0, rtok_o}, 32'h7);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    cnt = 0;
    #1;
    check("R2 write token at first slice", {29'd0, wtok_t}, 32'h1);
    check("R2 read token at first slice", {29'd0, rtok_t}, 32'h1);
    check("R1 ring slices in ring mode", {29'd0, solo_m}, 32'h0);
    run_mon = 1'b1;
  endtask

  // Monitor: single-owner rule, enable gating and scoreboard.
  always @(negedge clk) begin
    #1;
    if (rst_n && run_mon) begin
      check("R6 single write owner", $countones(wtok_t), 1);
      check("R6 single read owner", $countones(rtok_t), 1);
      check("R3 write enables follow strobe", $countones(wr_en), {31'd0, wr_stb});
      check("R3 read enables follow strobe", $countones(rd_en), {31'd0, rd_stb});
      for (int s = 0; s < NS; s++) begin
        if (rd_en[s]) begin
          if (exp_q.size() == 0) check("R6 read with empty scoreboard", 1, 0);
          else check("R6 data order across slices", {24'd0, smem[s][rp[s]]}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    din = 8'h10;
    s_wr = 1'b0; s_rd = 1'b0; s_wl = 1'b0; s_rl = 1'b0; s_hf = 1'b0; s_xin = 1'b0;
    do_reset();

    // Solo instance captured standalone mode while its input was low.
    check("R1 solo mode captured", {31'd0, s_mode}, 1);
    check("R7 solo owns write", {31'd0, s_wt}, 1);
    check("R7 solo owns read", {31'd0, s_rt}, 1);

    // Phase A: fill one slice, watch the write pulse.
    for (int i = 0; i < 3; i++) cyc(1, 0);
    cyc(1, 0);
    check("R4 pulse on last write of slice 0", {29'd0, wtok_o}, 32'h6);
    cyc(0, 0);
    check("R4 R5 write token moved to slice 1", {29'd0, wtok_t}, 32'h2);
    check("R3 non-owner read token unchanged", {29'd0, rtok_t}, 32'h1);
    for (int i = 0; i < 8; i++) cyc(1, 0);
    cyc(0, 0);
    check("R5 write token wrapped to slice 0", {29'd0, wtok_t}, 32'h1);
    for (int i = 0; i < 4; i++) cyc(0, 1);
    cyc(0, 0);
    check("R6 read token moved to slice 1", {29'd0, rtok_t}, 32'h2);
    while (cnt > 0) cyc(0, 1);
    cyc(0, 0);
    check("R6 read token wrapped to slice 0", {29'd0, rtok_t}, 32'h1);
    check("R6 scoreboard drained", exp_q.size(), 0);

    // Phase B: simultaneous hand-offs.
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 1);
    cyc(1, 1);
    check("R8 write pulse from slice 1", {29'd0, wtok_o}, 32'h5);
    check("R8 read pulse from slice 0", {29'd0, rtok_o}, 32'h6);
    cyc(0, 0);
    check("R8 write token at slice 2", {29'd0, wtok_t}, 32'h4);
    check("R8 read token at slice 1", {29'd0, rtok_t}, 32'h2);
    while (cnt > 0) cyc(0, 1);

    // Phase C: long mixed stream.
    for (int i = 0; i < 60; i++) begin
      logic w, r;
      w = (cnt < NS * DEPTH) && ((i % 3) != 2);
      r = (cnt > 0) && ((i % 2) == 0);
      cyc(w, r);
    end
    while (cnt > 0) cyc(0, 1);
    cyc(0, 0);
    check("R6 mixed stream fully delivered", exp_q.size(), 0);

    // Phase D: standalone behaviour with inputs changing after reset.
    @(negedge clk);
    s_xin = 1'b1; s_hf = 1'b1; s_wr = 1'b1; s_wl = 1'b1; s_rd = 1'b1; s_rl = 1'b1;
    #1;
    check("R7 solo forwards half-full", {31'd0, s_wo}, 0);
    check("R7 solo read line idle", {31'd0, s_ro}, 1);
    check("R3 solo write enable", {31'd0, s_wen}, 1);
    check("R3 solo read enable", {31'd0, s_ren}, 1);
    @(negedge clk);
    s_hf = 1'b0; s_wr = 1'b0; s_rd = 1'b0;
    #1;
    check("R7 solo half-full cleared", {31'd0, s_wo}, 1);
    check("R1 solo mode held after input change", {31'd0, s_mode}, 1);
    check("R7 solo keeps write token", {31'd0, s_wt}, 1);
    check("R3 solo enable drops with strobe", {31'd0, s_wen}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule